// File: doc/BRIEF.md
# Jiffy Interval Timer

A periodic interrupt source for system timekeeping. A down-counter steps once for every cycle in which a reference-clock enable is high. That enable comes from an oscillator that is independent of the processor bus clock, so the interrupt rate does not move when the processor clock is retuned. When the counter is at zero and another step arrives, it reloads from a software-written latch and raises an event flag. The period is therefore the latch value plus one enable pulse. With a reference near 1 MHz, values such as 0x4025 or 0x4295 give a rate close to 60 Hz.

Software reaches four registers through a small single-cycle bus: the reload latch, a control word, the event status and the live count. Reading the status returns the flag and clears it. The block guarantees that an event landing in the same cycle as that read, or one or two cycles after it, is never lost. The interrupt output is a level that follows the flag, gated by an enable bit.

Top module: `jiffy_timer`

## Requirements
- R1: After reset the latch and the count read 0xFFFF, and the control word, the status and `irq` are all 0.
- R2: While the run bit (control bit 0) is 1, the count drops by one at the end of each cycle in which `tick_en` is high. A cycle with `tick_en` low, or with run at 0, leaves the count unchanged.
- R3: When the count is 0 and a counting step occurs, the count takes the latch value and status bit 0 is set at that clock edge. This also holds for a latch value of 0, which gives an event on every step.
- R4: A control write with bit 2 set copies the latch into the count at that edge. This overrides a step in the same cycle and raises no event. Bit 2 reads back as 0.
- R5: A read of the status register (address 2) returns the flag in bit 0 and clears it at the end of the read cycle.
- R6: If an event and a status read fall in the same cycle, that read returns the earlier flag value, the flag is 1 afterwards, and the next read returns 1.
- R7: An event one or two cycles after a status read still sets the flag, and the next read returns 1.
- R8: `irq` is high exactly while the flag is 1 and the interrupt-enable bit (control bit 1) is 1. Clearing the enable masks `irq` but leaves the flag intact.
- R9: Writes to addresses 2 and 3 change nothing. A latch write does not change a count already in progress until the next reload or force load.
- R10: Address 0 is the latch (read and write), address 1 is control (bits 1:0 read back), address 2 is status, and address 3 is the count (read only). `rdata` is 0 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle step enable derived from the reference clock |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, valid in the read cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The underflow event and the clear-on-read of the status register can collide in one cycle. The bench counts the counter down to zero under program control. It then places a status read exactly on the stepping cycle, and also one and two cycles before it. The value each read returns and the value the following read returns are compared with hand-derived results. A force load issued on a stepping cycle with the count at zero is judged by whether the flag stays clear.

// File: rtl/jiffy_pkg.sv
package jiffy_pkg;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_CTRL   = 2'd1,
        REG_STATUS = 2'd2,
        REG_COUNT  = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_IEN_BIT  = 1;
    localparam int CTRL_LOAD_BIT = 2;

    typedef struct packed {
        logic ien;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic wr_reload;
        logic wr_ctrl;
        logic force_load;
        logic rd_status;
    } bus_ev_t;

    function automatic logic is_access(input logic sel, input logic wr,
                                       input logic want_wr);
        return sel && (wr == want_wr);
    endfunction

endpackage

// File: rtl/jiffy_regs.sv
module jiffy_regs
    import jiffy_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_RELOAD = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             flag,
    output logic [CNT_W-1:0] reload,
    output ctrl_t            ctrl,
    output bus_ev_t          ev,
    output logic [CNT_W-1:0] bus_rdata
);
    localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(RST_RELOAD);

    reg_sel_e sel_reg;
    logic     do_wr;
    logic     do_rd;

    assign sel_reg = reg_sel_e'(bus_addr);
    assign do_wr   = is_access(bus_sel, bus_wr, 1'b1);
    assign do_rd   = is_access(bus_sel, bus_wr, 1'b0);

    always_comb begin
        ev            = '0;
        ev.wr_reload  = do_wr && (sel_reg == REG_RELOAD);
        ev.wr_ctrl    = do_wr && (sel_reg == REG_CTRL);
        ev.force_load = ev.wr_ctrl && bus_wdata[CTRL_LOAD_BIT];
        ev.rd_status  = do_rd && (sel_reg == REG_STATUS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= RELOAD_INIT;
            ctrl   <= '0;
        end else begin
            if (ev.wr_reload) reload <= bus_wdata;
            if (ev.wr_ctrl) begin
                ctrl.run <= bus_wdata[CTRL_RUN_BIT];
                ctrl.ien <= bus_wdata[CTRL_IEN_BIT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            unique case (sel_reg)
                REG_RELOAD: bus_rdata = reload;
                REG_CTRL:   bus_rdata[1:0] = ctrl;
                REG_STATUS: bus_rdata[0] = flag;
                REG_COUNT:  bus_rdata = count;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R10: a control write is visible in the control word one cycle later
    p_ctrl_write_r10: assert property (@(posedge clk) disable iff (rst)
        ev.wr_ctrl |=> (ctrl.run == $past(bus_wdata[CTRL_RUN_BIT]))
                    && (ctrl.ien == $past(bus_wdata[CTRL_IEN_BIT])));

    // R9: the latch only changes through an address-0 write
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !ev.wr_reload |=> $stable(reload));

endmodule

// File: rtl/jiffy_counter.sv
module jiffy_counter
    import jiffy_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_RELOAD = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             run,
    input  logic             force_load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] COUNT_INIT = CNT_W'(RST_RELOAD);

    logic step;
    logic at_zero;

    assign step      = run && tick_en && !force_load;
    assign at_zero   = (count == '0);
    assign underflow = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= COUNT_INIT;
        end else if (force_load) begin
            count <= reload;
        end else if (step) begin
            count <= at_zero ? reload : count - 1'b1;
        end
    end

    // R2: one decrement per enabled step above zero
    p_decrement_r2: assert property (@(posedge clk) disable iff (rst)
        (run && tick_en && !force_load && count != '0)
            |=> count == $past(count) - 1'b1);

    // R2: no step, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!(run && tick_en) && !force_load) |=> $stable(count));

    // R3: underflow reloads from the latch
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        underflow |=> count == $past(reload));

    // R4: force load copies the latch at once
    p_force_r4: assert property (@(posedge clk) disable iff (rst)
        force_load |=> count == $past(reload));

endmodule

// File: rtl/jiffy_flag.sv
module jiffy_flag (
    input  logic clk,
    input  logic rst,
    input  logic underflow,
    input  logic rd_status,
    input  logic ien,
    output logic flag,
    output logic irq
);
    // An event outranks the clear so a colliding read never drops it.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (underflow) begin
            flag <= 1'b1;
        end else if (rd_status) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && ien;

    // R3 / R6: an event always leaves the flag set
    p_event_sets_r6: assert property (@(posedge clk) disable iff (rst)
        underflow |=> flag);

    // R5: a read with no colliding event clears the flag
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !underflow) |=> !flag);

    // R7: without read or event the flag keeps its value
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_status && !underflow) |=> $stable(flag));

endmodule

// File: rtl/jiffy_timer.sv
module jiffy_timer
    import jiffy_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_RELOAD = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;
    bus_ev_t          ev;
    logic             underflow;
    logic             flag;

    jiffy_regs #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .flag(flag),
        .reload(reload), .ctrl(ctrl), .ev(ev), .bus_rdata(bus_rdata)
    );

    jiffy_counter #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en), .run(ctrl.run),
        .force_load(ev.force_load), .reload(reload),
        .count(count), .underflow(underflow)
    );

    jiffy_flag u_flag (
        .clk(clk), .rst(rst), .underflow(underflow),
        .rd_status(ev.rd_status), .ien(ctrl.ien),
        .flag(flag), .irq(irq)
    );

    // R8: the request drops one cycle after the enable is written to 0
    p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.wr_ctrl && !bus_wdata[CTRL_IEN_BIT]) |=> !irq);

endmodule

// File: tb/jiffy_timer_tb_top.sv
`timescale 1ns/1ps
module jiffy_timer_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_en = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    jiffy_timer dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model built from the requirements
    logic [W-1:0] m_latch, m_cnt;
    logic         m_run, m_ien, m_flag;

    always @(posedge clk) begin
        logic rd_s, frc, uf;
        if (rst) begin
            m_latch = 16'hFFFF; m_cnt = 16'hFFFF;
            m_run = 0; m_ien = 0; m_flag = 0;
        end else begin
            rd_s = bus_sel && !bus_wr && bus_addr == 2'd2;
            frc  = bus_sel && bus_wr && bus_addr == 2'd1 && bus_wdata[2];
            uf   = m_run && tick_en && !frc && m_cnt == 0;
            if (uf) m_flag = 1'b1;
            else if (rd_s) m_flag = 1'b0;
            if (frc) m_cnt = m_latch;
            else if (m_run && tick_en) m_cnt = (m_cnt == 0) ? m_latch : m_cnt - 1'b1;
            if (bus_sel && bus_wr && bus_addr == 2'd0) m_latch = bus_wdata;
            if (bus_sel && bus_wr && bus_addr == 2'd1) begin
                m_run = bus_wdata[0]; m_ien = bus_wdata[1];
            end
        end
    end

    function automatic logic [W-1:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_latch;
            2'd1: return {14'd0, m_ien, m_run};
            2'd2: return {15'd0, m_flag};
            default: return m_cnt;
        endcase
    endfunction

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;
    item_t sb[$];

    task automatic drive(input logic s, input logic w, input logic [1:0] a,
                         input logic [W-1:0] d, input logic t);
        @(posedge clk);
        #1;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = t;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic t = 0);
        item_t it;
        drive(1, 0, a, '0, t);
        it.exp = model_rd(a); it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rdx(input logic [1:0] a, input logic [W-1:0] e,
                       input string tag, input logic t = 0);
        item_t it;
        drive(1, 0, a, '0, t);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic t = 0);
        drive(1, 1, a, d, t);
    endtask

    task automatic idle(input logic t);
        drive(0, 0, 2'd0, '0, t);
    endtask

    // monitor: compares read data and the interrupt level at mid-cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (bus_sel && !bus_wr) begin
                item_t it;
                if (sb.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R10: read with empty scoreboard, actual=%h expected=none", bus_rdata);
                end else begin
                    it = sb.pop_front();
                    total++;
                    if (bus_rdata !== it.exp) begin
                        bad++;
                        $display("FAIL %s: addr=%0d actual=%h expected=%h",
                                 it.tag, bus_addr, bus_rdata, it.exp);
                    end
                end
            end else begin
                total++;
                if (bus_rdata !== '0) begin
                    bad++;
                    $display("FAIL R10: idle rdata actual=%h expected=0", bus_rdata);
                end
            end
            total++;
            if (irq !== (m_flag && m_ien)) begin
                bad++;
                $display("FAIL R8: irq actual=%b expected=%b", irq, m_flag && m_ien);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset values
        rdx(2'd0, 16'hFFFF, "R1");
        rdx(2'd1, 16'h0000, "R1");
        rdx(2'd2, 16'h0000, "R1");
        rdx(2'd3, 16'hFFFF, "R1");

        // R10 latch write and read back, R4 force load
        wr(2'd0, 16'd5);
        rdx(2'd0, 16'd5, "R10");
        wr(2'd1, 16'h0004);
        rdx(2'd3, 16'd5, "R4");
        rdx(2'd1, 16'h0000, "R4");

        // R2 counting with gaps in the enable
        wr(2'd1, 16'h0003);
        idle(1); idle(0); idle(1); idle(0); idle(0);
        rdx(2'd3, 16'd3, "R2");
        wr(2'd1, 16'h0002);
        idle(1); idle(1);
        rdx(2'd3, 16'd3, "R2");

        // R3 underflow and reload, period latch+1
        wr(2'd1, 16'h0003);
        idle(1); idle(1); idle(1);
        rdx(2'd3, 16'd0, "R3");
        rdx(2'd2, 16'd0, "R3");
        idle(1);
        rdx(2'd3, 16'd5, "R3");
        rdx(2'd2, 16'd1, "R5");
        rdx(2'd2, 16'd0, "R5");

        // R6 read on the event cycle
        wr(2'd0, 16'd3);
        wr(2'd1, 16'h0007);
        idle(1); idle(1); idle(1);
        rdx(2'd2, 16'd0, "R6", 1);
        rdx(2'd2, 16'd1, "R6");
        rdx(2'd2, 16'd0, "R6");

        // R7 read one cycle before the event
        idle(1); idle(1); idle(1);
        rdx(2'd2, 16'd0, "R7");
        idle(1);
        rdx(2'd2, 16'd1, "R7");
        // R7 read two cycles before the event
        idle(1); idle(1); idle(1);
        rdx(2'd2, 16'd0, "R7");
        idle(0);
        idle(1);
        rdx(2'd2, 16'd1, "R7");

        // R8 masking keeps the flag
        idle(1); idle(1); idle(1); idle(1);
        idle(0);
        wr(2'd1, 16'h0001);
        idle(0);
        rdx(2'd2, 16'd1, "R8");

        // R9 ignored writes
        wr(2'd1, 16'h0000);
        rd(2'd3, "R9");
        wr(2'd3, 16'h1234);
        rd(2'd3, "R9");
        wr(2'd2, 16'h0001);
        rdx(2'd2, 16'd0, "R9");
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'd10, 1);
        idle(1);
        rd(2'd3, "R9");

        // R4 force on a step at zero gives no event; R3 with latch 0
        wr(2'd0, 16'd0);
        wr(2'd1, 16'h0005);
        rd(2'd2, "R5");
        wr(2'd1, 16'h0007, 1);
        rdx(2'd2, 16'd0, "R4");
        idle(1);
        rdx(2'd2, 16'd1, "R3");
        rdx(2'd3, 16'd0, "R3");

        // R2 R3 R5 mixed pattern against the model
        wr(2'd0, 16'd7);
        wr(2'd1, 16'h0007);
        for (int i = 0; i < 300; i++) begin
            if (i % 7 == 0)      rd(2'd2, "R5", (i % 3) != 0);
            else if (i % 5 == 0) rd(2'd3, "R2", (i % 3) != 0);
            else                 idle((i % 3) != 0);
        end
        idle(0);
        idle(0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule